// File: doc/BRIEF.md
# Core Register Window Access Guard

This block sits in the core's data-access path, in front of the core control-register space. Every load or store that targets the 1 MB register window at 0xFFE00000 is checked in three layers before it is forwarded. First, address bits [19:16] must be zero. Second, the peripheral index in bits [15:12] must be no greater than 8. Third, the word offset inside that peripheral's 4 KB slot must lie inside the peripheral's populated span. Accesses outside the window are passed on unchecked.

An access that fails any layer is not forwarded, so a store to a hole never reaches a register. In the same cycle the block pulses a protection exception. At the next clock edge it records the protection cause code 0x2E, the full offending address and the PC of the faulting access itself. The cause, address and PC registers keep their values until the next violation. Software may also load the fault-address register directly, for example to put it in a known state before a test.

Top module: `mmr_addr_guard`

## Requirements
- R1: An access whose address bits [31:20] differ from 0xFFE is forwarded with address, direction and data unchanged and never raises an exception.
- R2: A valid access with bits [31:20] equal to 0xFFE and any of bits [19:16] set is illegal.
- R3: A valid access in the window with bits [19:16] zero and peripheral index bits [15:12] greater than 8 is illegal.
- R4: For peripheral p in 0..8, the access is legal only if the word index, taken from bits [11:2], is below span[p]. Bits [1:0] are ignored. With the default spans the first illegal offsets are: 0x408 for p0 and p1, 0x114 for p2, 0x010 for p3 and p5, 0x008 for p4, 0x104 for p6, 0x204 for p7, and 0x108 for p8.
- R5: An illegal access drives fwd_valid_o and fwd_we_o low in the same cycle, so a blocked store updates nothing. A legal access drives fwd_valid_o high, and fwd_we_o equals req_we_i.
- R6: exc_o is high exactly in each cycle that carries a valid illegal access. After that clock edge exc_cause_o reads 0x2E and holds it.
- R7: On a violation, fault_addr_o takes the full 32-bit request address at the clock edge. Without a violation, a cycle with fault_wr_i high loads fault_wdata_i. A violation wins over a software write in the same cycle. In any other cycle the register holds.
- R8: On a violation, ret_pc_o takes the req_pc_i of the faulting access at the clock edge and holds it until the next violation.
- R9: While rst_ni is low, exc_o is low and fault_addr_o, ret_pc_o and exc_cause_o are zero.
- R10: With req_valid_i low, fwd_valid_o and exc_o stay low and the capture registers are unchanged, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request valid |
| req_addr_i | input | 32 | Access byte address |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_wdata_i | input | 32 | Store data |
| req_pc_i | input | 32 | PC of the accessing instruction |
| fault_wr_i | input | 1 | Software load of the fault-address register |
| fault_wdata_i | input | 32 | Value for the software load |
| fwd_valid_o | output | 1 | Forwarded access valid |
| fwd_addr_o | output | 32 | Forwarded address |
| fwd_we_o | output | 1 | Forwarded store enable |
| fwd_wdata_o | output | 32 | Forwarded store data |
| exc_o | output | 1 | Protection exception pulse |
| exc_cause_o | output | 6 | Latched exception cause |
| fault_addr_o | output | 32 | Latched faulting address |
| ret_pc_o | output | 32 | Latched PC of the faulting access |

## Verification
Every peripheral index from 0 to 15 is swept against all 1024 word offsets, with the byte lane rotating. This separates the index-limit layer from the per-peripheral span boundary, and shows that bits [1:0] have no effect. Each nonzero value of bits [19:16] is tried over legal peripheral offsets, so a nibble failure cannot be hidden by a legal lower field. Addresses just outside the window on either side, in which the lower fields would look illegal, confirm pass-through. Register capture is then exercised on its own: back-to-back violations, idle cycles with illegal addresses, software loads, and a software load that collides with a violation.

// File: rtl/mmr_guard_pkg.sv
package mmr_guard_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned OFF_W   = 12;           // 4 KB slot
  localparam int unsigned WORD_W  = OFF_W - 2;    // word index width
  localparam int unsigned SPAN_W  = WORD_W + 1;   // span may equal 1024
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned TAG_W   = ADDR_W - OFF_W - IDX_W - NIB_W;
  localparam int unsigned CAUSE_W = 6;

  typedef logic [CAUSE_W-1:0] cause_t;
  localparam cause_t CAUSE_PROT = 6'h2E;

  localparam logic [TAG_W-1:0] WIN_TAG = 12'hFFE;

  // populated words per peripheral, entry 8 first
  localparam logic [8:0][SPAN_W-1:0] DEF_SPAN = {
    11'h042, 11'h081, 11'h041, 11'h004, 11'h002,
    11'h004, 11'h045, 11'h102, 11'h102
  };
endpackage

// File: rtl/mmr_addr_decode.sv
module mmr_addr_decode
  import mmr_guard_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 9
) (
  input  logic [ADDR_W-1:2]  addr_i,
  output logic               in_win_o,
  output logic               nib_bad_o,
  output logic               idx_bad_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [WORD_W-1:0]  word_o
);
  localparam int unsigned IDX_LSB = OFF_W;
  localparam int unsigned NIB_LSB = OFF_W + IDX_W;
  localparam int unsigned TAG_LSB = NIB_LSB + NIB_W;

  always_comb begin
    in_win_o  = addr_i[ADDR_W-1:TAG_LSB] == WIN_TAG;
    nib_bad_o = |addr_i[TAG_LSB-1:NIB_LSB];
    idx_o     = addr_i[NIB_LSB-1:IDX_LSB];
    idx_bad_o = 32'(idx_o) >= NUM_PERIPH;
    word_o    = addr_i[OFF_W-1:2];
  end
endmodule

// File: rtl/mmr_offset_table.sv
module mmr_offset_table
  import mmr_guard_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 9,
  parameter logic [NUM_PERIPH-1:0][SPAN_W-1:0] SPAN_WORDS = DEF_SPAN
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              legal_o
);
  logic [NUM_PERIPH-1:0] hit;

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
    assign hit[p] = (32'(idx_i) == p) &&
                    ({1'b0, word_i} < SPAN_WORDS[p]);
  end

  assign legal_o = |hit;
endmodule

// File: rtl/mmr_fault_regs.sv
module mmr_fault_regs
  import mmr_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              sw_wr_i,
  input  logic [ADDR_W-1:0] sw_wdata_i,
  output cause_t            cause_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [ADDR_W-1:0] ret_pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o      <= '0;
      fault_addr_o <= '0;
      ret_pc_o     <= '0;
    end else if (exc_i) begin
      cause_o      <= CAUSE_PROT;
      fault_addr_o <= addr_i;
      ret_pc_o     <= pc_i;
    end else if (sw_wr_i) begin
      fault_addr_o <= sw_wdata_i;
    end
  end
endmodule

// File: rtl/mmr_addr_guard.sv
module mmr_addr_guard
  import mmr_guard_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 9,
  parameter logic [NUM_PERIPH-1:0][SPAN_W-1:0] SPAN_WORDS = DEF_SPAN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_wdata_i,
  input  logic [ADDR_W-1:0] req_pc_i,
  input  logic              fault_wr_i,
  input  logic [ADDR_W-1:0] fault_wdata_i,
  output logic              fwd_valid_o,
  output logic [ADDR_W-1:0] fwd_addr_o,
  output logic              fwd_we_o,
  output logic [ADDR_W-1:0] fwd_wdata_o,
  output logic              exc_o,
  output cause_t            exc_cause_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [ADDR_W-1:0] ret_pc_o
);
  logic              in_win, nib_bad, idx_bad, off_ok, illegal;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word;

  mmr_addr_decode #(.NUM_PERIPH(NUM_PERIPH)) u_dec (
    .addr_i    (req_addr_i[ADDR_W-1:2]),
    .in_win_o  (in_win),
    .nib_bad_o (nib_bad),
    .idx_bad_o (idx_bad),
    .idx_o     (idx),
    .word_o    (word)
  );

  mmr_offset_table #(.NUM_PERIPH(NUM_PERIPH), .SPAN_WORDS(SPAN_WORDS)) u_tbl (
    .idx_i   (idx),
    .word_i  (word),
    .legal_o (off_ok)
  );

  // layered check, one cause for every layer
  assign illegal = in_win && (nib_bad || idx_bad || !off_ok);

  assign exc_o       = req_valid_i && illegal;
  assign fwd_valid_o = req_valid_i && !illegal;
  assign fwd_we_o    = fwd_valid_o && req_we_i;
  assign fwd_addr_o  = req_addr_i;
  assign fwd_wdata_o = req_wdata_i;

  mmr_fault_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .exc_i        (exc_o),
    .addr_i       (req_addr_i),
    .pc_i         (req_pc_i),
    .sw_wr_i      (fault_wr_i),
    .sw_wdata_i   (fault_wdata_i),
    .cause_o      (exc_cause_o),
    .fault_addr_o (fault_addr_o),
    .ret_pc_o     (ret_pc_o)
  );
endmodule

// File: rtl/mmr_addr_guard_chk.sv
module mmr_addr_guard_chk
  import mmr_guard_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [ADDR_W-1:0] req_pc_i,
  input logic              fault_wr_i,
  input logic              fwd_valid_o,
  input logic              exc_o,
  input cause_t            exc_cause_o,
  input logic [ADDR_W-1:0] fault_addr_o,
  input logic [ADDR_W-1:0] ret_pc_o
);
  logic win;
  assign win = req_addr_i[31:20] == WIN_TAG;

  AST_OUTSIDE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !win |-> fwd_valid_o && !exc_o); // R1
  AST_NIBBLE_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && win && (req_addr_i[19:16] != 4'h0) |-> exc_o); // R2
  AST_INDEX_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && win && (32'(req_addr_i[15:12]) >= NUM_PERIPH) |-> exc_o); // R3
  AST_BLOCK_ON_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !fwd_valid_o); // R5
  AST_CAUSE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> exc_cause_o == CAUSE_PROT); // R6
  AST_FAULT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> fault_addr_o == $past(req_addr_i)); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o && !fault_wr_i |=> $stable(fault_addr_o)); // R7
  AST_RETPC_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> ret_pc_o == $past(req_pc_i)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !exc_o && !fwd_valid_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(ret_pc_o) && $stable(exc_cause_o)); // R10
endmodule

bind mmr_addr_guard mmr_addr_guard_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .req_pc_i     (req_pc_i),
  .fault_wr_i   (fault_wr_i),
  .fwd_valid_o  (fwd_valid_o),
  .exc_o        (exc_o),
  .exc_cause_o  (exc_cause_o),
  .fault_addr_o (fault_addr_o),
  .ret_pc_o     (ret_pc_o)
);

// File: tb/mmr_addr_guard_tb.sv
module mmr_addr_guard_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_we_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic [31:0] req_pc_i = '0;
  logic        fault_wr_i = 1'b0;
  logic [31:0] fault_wdata_i = '0;
  logic        fwd_valid_o, fwd_we_o, exc_o;
  logic [31:0] fwd_addr_o, fwd_wdata_o, fault_addr_o, ret_pc_o;
  logic [5:0]  exc_cause_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [31:0] m_fault = '0;
  logic [31:0] m_pc = '0;
  logic [5:0]  m_cause = '0;

  mmr_addr_guard u_dut (.*);

  always #2 clk_i = ~clk_i; // 250 MHz

  function automatic logic [31:0] hole_off(int p);
    case (p)
      0, 1:    return 32'h408;
      2:       return 32'h114;
      3, 5:    return 32'h010;
      4:       return 32'h008;
      6:       return 32'h104;
      7:       return 32'h204;
      default: return 32'h108;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one cycle: check registers from previous edge, drive, check combinational outputs
  task automatic step(bit v, logic [31:0] a, bit we, logic [31:0] pc,
                      bit swr, logic [31:0] swd);
    bit win, ill, e_exc, e_fv;
    string tag;
    @(negedge clk_i);
    chk(fault_addr_o == m_fault, "R7", fault_addr_o, m_fault);
    chk(ret_pc_o == m_pc, "R8", ret_pc_o, m_pc);
    chk(exc_cause_o == m_cause, "R6", 32'(exc_cause_o), 32'(m_cause));
    req_valid_i = v; req_addr_i = a; req_we_i = we;
    req_wdata_i = ~a; req_pc_i = pc; fault_wr_i = swr; fault_wdata_i = swd;
    #1;
    win = a[31:20] == 12'hFFE;
    tag = "R4";
    if (!win) begin ill = 0; tag = "R1"; end
    else if (a[19:16] != 0) begin ill = 1; tag = "R2"; end
    else if (a[15:12] > 8) begin ill = 1; tag = "R3"; end
    else ill = (a[11:0] & 12'hFFC) >= hole_off(int'(a[15:12]));
    if (!v) tag = "R10";
    e_exc = v && ill;
    e_fv  = v && !ill;
    chk(exc_o == e_exc, tag, 32'(exc_o), 32'(e_exc));
    chk(fwd_valid_o == e_fv, tag, 32'(fwd_valid_o), 32'(e_fv));
    chk(fwd_we_o == (e_fv && we), "R5", 32'(fwd_we_o), 32'(e_fv && we));
    if (e_fv) begin
      chk(fwd_addr_o == a, "R5", fwd_addr_o, a);
      chk(fwd_wdata_o == ~a, "R5", fwd_wdata_o, ~a);
    end
    if (e_exc) begin m_fault = a; m_pc = pc; m_cause = 6'h2E; end
    else if (swr) m_fault = swd;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(!exc_o, "R9", 32'(exc_o), 0);
    chk(fault_addr_o == 0, "R9", fault_addr_o, 0);
    chk(ret_pc_o == 0, "R9", ret_pc_o, 0);
    chk(exc_cause_o == 0, "R9", 32'(exc_cause_o), 0);
    rst_ni = 1'b1;

    // R3 R4: full sweep of index x word, rotating byte lane
    for (int p = 0; p < 16; p++)
      for (int w = 0; w < 1024; w++)
        step(1, 32'hFFE00000 | (p << 12) | (w << 2) | (w & 3), w[0],
             32'h1000_0000 + (p << 12) + w, 0, 0);

    // R2: every nonzero upper nibble with otherwise legal fields
    for (int n = 1; n < 16; n++)
      for (int o = 0; o < 4; o++)
        step(1, 32'hFFE00000 | (n << 16) | (o << 2), 1, 32'h2000_0000 + n, 0, 0);

    // R1: outside the window on both sides
    step(1, 32'hFFDFFFFC, 1, 32'h30, 0, 0);
    step(1, 32'hFFF09408, 1, 32'h34, 0, 0);
    step(1, 32'h00000408, 0, 32'h38, 0, 0);
    step(1, 32'hEFE08108, 1, 32'h3C, 0, 0);

    // R10: idle with illegal addresses, registers hold
    step(1, 32'hFFE09000, 1, 32'h40, 0, 0);
    step(0, 32'hFFE10000, 1, 32'h44, 0, 0);
    step(0, 32'hFFE00408, 1, 32'h48, 0, 0);

    // R7: software load, then collision with a violation
    step(0, 32'h0, 0, 32'h0, 1, 32'h0);
    step(1, 32'hFFE00404, 1, 32'h50, 1, 32'h12345678);
    step(1, 32'hFFE03010, 1, 32'h54, 1, 32'hCAFEF00D);
    step(0, 32'h0, 0, 32'h0, 0, 32'h0);

    // R8: back-to-back violations with distinct PCs
    step(1, 32'hFFE02114, 1, 32'h60, 0, 0);
    step(1, 32'hFFE07204, 0, 32'h64, 0, 0);
    step(1, 32'hFFE08108, 1, 32'h68, 0, 0);
    step(0, 32'h0, 0, 32'h0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule